// File: doc/BRIEF.md
# Fully Associative Page Mapping Unit

This block turns 32-bit virtual addresses into physical addresses using a small, fully associative table of mapping entries. A page holds 1024 words. The upper 20 address bits form the virtual page number, and the lower 12 bits go through unchanged. Each request names an access kind: read, write or execute. If the table has no usable entry for the page, or the entry does not grant that kind of access, the unit raises a trap. It then records the faulting address together with a cause code in its trap-address register.

Software fills and inspects the table through two registers. The trap-address register selects a page. The data register reads back, or writes, the mapping for that page. When a write has the global bit set, the table does not store a mapping. Instead the written rights bits are ANDed into every entry, so writing zeros invalidates the whole table. Translation is active only while the top bit of a 4-bit privilege level input is set. Below that level, every address passes through untouched.

Top module: `page_map_unit`

## Requirements
- R1: After a synchronous reset, `rsp_valid_o`, `rsp_trap_o`, `tma_o` and `dat_o` are zero and the table holds no entries, so every translated request misses.
- R2: When `lvl_i[3]` is 0, a request returns `rsp_addr_o` equal to `req_addr_i` with `rsp_trap_o` low, one cycle after the request.
- R3: When `lvl_i[3]` is 1 and an entry for `req_addr_i[31:12]` has V=1 and grants the access, `rsp_addr_o` is `{entry ppn, req_addr_i[11:0]}` one cycle later, with no trap.
- R4: Access kinds are coded on `req_kind_i` as 00 read, 01 write, 10 execute, and 11 checked as a read. A trap is raised for a miss or V=0 (cause 01), for a read without R or an execute without X (cause 10), and for a write without W (cause 11). On a trap, `rsp_addr_o` carries the untranslated address.
- R5: On a trap, `tma_o` becomes `{req_addr_i[31:2], cause}`. A trap takes precedence over a software write to `tma_o` in the same cycle.
- R6: `dat_o` shows the entry whose page equals `tma_o[31:12]`. The layout is: ppn in [31:12], zeros in [11:5] (G reads 0), C in [4], R in [3], W in [2], X in [1], V in [0]. If no entry holds that page, `dat_o` is 0.
- R7: A data write with G (bit 5) at 0 overwrites, in place, the entry for page `tma_o[31:12]` if one exists. Otherwise it fills the entry under a round-robin pointer. That pointer starts at 0, advances only on such a fill, and wraps after the last entry.
- R8: A data write with G=1 ANDs bits [4:0] into the C, R, W, X and V bits of every entry. It leaves page numbers unchanged and fills no entry.
- R9: A request in the same cycle as a data write is judged against the table contents from before that write.
- R10: `rsp_valid_o` is `req_valid_i` delayed by one cycle. `tma_o` changes only on a trap or on a software write to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_i | input | 4 | Privilege level; bit 3 enables translation |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| tma_wr_i | input | 1 | Write strobe for the trap-address register |
| tma_wdata_i | input | 32 | Value written to the trap-address register |
| dat_wr_i | input | 1 | Write strobe for the data register |
| dat_wdata_i | input | 32 | Mapping value or global rights mask |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_addr_o | output | 32 | Physical (or passed-through) address |
| rsp_trap_o | output | 1 | Trap requested for the response |
| tma_o | output | 32 | Trap-address register |
| dat_o | output | 32 | Entry for the page selected by `tma_o` |

## Verification
Two pairs of functions can fire in the same clock. A lookup can meet a software table write, and a trap capture can meet a software write to the trap-address register. The bench provokes both pairs deliberately. It issues a write-access request in the same cycle as a data write that would grant W, and it issues a missing request together with a trap-address write. It then judges the response and `tma_o` against a behavioural model that always evaluates the request on the old table and lets the trap win. Random traffic over a small pool of pages repeats both collisions many times, and every output is compared with the model on every clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int VPN_W = 20;
  localparam int OFF_W = 12;
  localparam int FLG_W = 5;

  localparam int FLG_V = 0;
  localparam int FLG_X = 1;
  localparam int FLG_W_BIT = 2;
  localparam int FLG_R = 3;
  localparam int G_BIT = 5;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_MISS = 2'b01,
    CAUSE_RX   = 2'b10,
    CAUSE_WR   = 2'b11
  } cause_e;
endpackage

// File: rtl/pmu_match.sv
module pmu_match #(
  parameter int NUM_ENTRIES = 4,
  parameter int KEY_W       = 20,
  localparam int IW         = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0][KEY_W-1:0] keys_i,
  input  logic [NUM_ENTRIES-1:0]            used_i,
  input  logic [KEY_W-1:0]                  key_i,
  output logic                              hit_o,
  output logic [IW-1:0]                     idx_o,
  output logic [NUM_ENTRIES-1:0]            hits_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hits_o[g] = used_i[g] && (keys_i[g] == key_i);
  end

  assign hit_o = |hits_o;

  // Lowest index wins; at most one bit is expected to be set.
  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hits_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pmu_rr_ptr.sv
module pmu_rr_ptr #(
  parameter int NUM_ENTRIES = 4,
  localparam int IW         = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);
  localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst)        ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> ptr_o <= LAST); // R7
endmodule

// File: rtl/page_map_unit.sv
module page_map_unit #(
  parameter int NUM_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  lvl_i,
  input  logic        req_valid_i,
  input  logic [31:0] req_addr_i,
  input  logic [1:0]  req_kind_i,
  input  logic        tma_wr_i,
  input  logic [31:0] tma_wdata_i,
  input  logic        dat_wr_i,
  input  logic [31:0] dat_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_addr_o,
  output logic        rsp_trap_o,
  output logic [31:0] tma_o,
  output logic [31:0] dat_o
);
  import pmu_pkg::*;

  localparam int IW    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int PAD_W = 32 - VPN_W - FLG_W;

  // Table state
  logic [NUM_ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0] ppn_q;
  logic [NUM_ENTRIES-1:0][FLG_W-1:0] flg_q;
  logic [NUM_ENTRIES-1:0]            used_q;

  logic unused_bits;
  assign unused_bits = ^{lvl_i[2:0], dat_wdata_i[OFF_W-1:G_BIT+1]};

  // Request-side search
  logic                   hit_req;
  logic [IW-1:0]          idx_req;
  logic [NUM_ENTRIES-1:0] hits_req;

  pmu_match #(.NUM_ENTRIES(NUM_ENTRIES), .KEY_W(VPN_W)) u_match_req (
    .keys_i (vpn_q),
    .used_i (used_q),
    .key_i  (req_addr_i[31:OFF_W]),
    .hit_o  (hit_req),
    .idx_o  (idx_req),
    .hits_o (hits_req)
  );

  // Software-side search, keyed by the trap-address register
  logic                   hit_sw;
  logic [IW-1:0]          idx_sw;
  logic [NUM_ENTRIES-1:0] hits_sw;

  pmu_match #(.NUM_ENTRIES(NUM_ENTRIES), .KEY_W(VPN_W)) u_match_sw (
    .keys_i (vpn_q),
    .used_i (used_q),
    .key_i  (tma_o[31:OFF_W]),
    .hit_o  (hit_sw),
    .idx_o  (idx_sw),
    .hits_o (hits_sw)
  );

  // Replacement pointer
  logic [IW-1:0] rr_ptr;
  logic          sw_map_wr;
  logic          sw_glob_wr;
  logic          alloc;
  logic [IW-1:0] wr_idx;

  assign sw_map_wr  = dat_wr_i && !dat_wdata_i[G_BIT];
  assign sw_glob_wr = dat_wr_i &&  dat_wdata_i[G_BIT];
  assign alloc      = sw_map_wr && !hit_sw;
  assign wr_idx     = hit_sw ? idx_sw : rr_ptr;

  pmu_rr_ptr #(.NUM_ENTRIES(NUM_ENTRIES)) u_rr (
    .clk   (clk),
    .rst   (rst),
    .adv_i (alloc),
    .ptr_o (rr_ptr)
  );

  // Entry update
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        vpn_q[g]  <= '0;
        ppn_q[g]  <= '0;
        flg_q[g]  <= '0;
        used_q[g] <= 1'b0;
      end else if (sw_glob_wr) begin
        flg_q[g] <= flg_q[g] & dat_wdata_i[FLG_W-1:0];
      end else if (sw_map_wr && (wr_idx == IW'(g))) begin
        vpn_q[g]  <= tma_o[31:OFF_W];
        ppn_q[g]  <= dat_wdata_i[31:OFF_W];
        flg_q[g]  <= dat_wdata_i[FLG_W-1:0];
        used_q[g] <= 1'b1;
      end
    end
  end

  // Rights check
  logic [FLG_W-1:0] flg_req;
  cause_e           cause;
  logic             trap_c;
  logic [31:0]      xaddr;

  assign flg_req = flg_q[idx_req];

  always_comb begin
    cause = CAUSE_NONE;
    if (lvl_i[3]) begin
      if (!hit_req || !flg_req[FLG_V]) begin
        cause = CAUSE_MISS;
      end else begin
        unique case (acc_e'(req_kind_i))
          ACC_WR:  if (!flg_req[FLG_W_BIT]) cause = CAUSE_WR;
          ACC_EX:  if (!flg_req[FLG_X])     cause = CAUSE_RX;
          default: if (!flg_req[FLG_R])     cause = CAUSE_RX;
        endcase
      end
    end
    trap_c = (cause != CAUSE_NONE);
    xaddr  = req_addr_i;
    if (lvl_i[3] && !trap_c) xaddr = {ppn_q[idx_req], req_addr_i[OFF_W-1:0]};
  end

  // Registered response and trap-address register
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_trap_o  <= 1'b0;
      tma_o       <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_trap_o  <= req_valid_i && trap_c;
      if (req_valid_i) rsp_addr_o <= xaddr;
      if (req_valid_i && trap_c) tma_o <= {req_addr_i[31:2], cause};
      else if (tma_wr_i)         tma_o <= tma_wdata_i;
    end
  end

  // Data register view of the selected page
  assign dat_o = hit_sw ? {ppn_q[idx_sw], {PAD_W{1'b0}}, flg_q[idx_sw]} : '0;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsp_valid_o == $past(req_valid_i)); // R10
  AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid_i) && !$past(lvl_i[3]))
      |-> (rsp_addr_o == $past(req_addr_i)) && !rsp_trap_o); // R2
  AST_TRAP_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_trap_o) |-> $past(req_valid_i) && $past(lvl_i[3])); // R4
  AST_TMA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !rsp_trap_o && !$past(tma_wr_i)) |-> $stable(tma_o)); // R10
  AST_REQ_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hits_req)); // R7
  AST_SW_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hits_sw)); // R7
endmodule

// File: tb/page_map_unit_tb.sv
module page_map_unit_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  lvl;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic        tma_wr;
  logic [31:0] tma_wdata;
  logic        dat_wr;
  logic [31:0] dat_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_trap;
  logic [31:0] tma;
  logic [31:0] dat;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  page_map_unit #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst(rst), .lvl_i(lvl),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_kind_i(req_kind),
    .tma_wr_i(tma_wr), .tma_wdata_i(tma_wdata),
    .dat_wr_i(dat_wr), .dat_wdata_i(dat_wdata),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_trap_o(rsp_trap),
    .tma_o(tma), .dat_o(dat)
  );

  // ---------------- behavioural reference model ----------------
  int          m_vpn [N];
  int          m_ppn [N];
  int          m_flg [N];
  bit          m_used[N];
  int          m_ptr;
  logic [31:0] m_tma;
  logic        e_valid, e_trap, e_byp;
  logic [31:0] e_addr;
  bit          cmp_en = 0;

  function automatic int m_find(input int page);
    for (int i = 0; i < N; i++) if (m_used[i] && m_vpn[i] == page) return i;
    return -1;
  endfunction

  function automatic logic [31:0] m_dat();
    int k;
    k = m_find(int'(m_tma[31:12]));
    if (k < 0) return 32'h0;
    return {m_ppn[k][19:0], 7'b0, m_flg[k][4:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_vpn[i] = 0; m_ppn[i] = 0; m_flg[i] = 0; m_used[i] = 0;
      end
      m_ptr = 0; m_tma = 0; e_valid = 0; e_trap = 0; e_addr = 0; e_byp = 0;
    end else begin
      logic [31:0] old_tma;
      int k, cz, slot;
      old_tma = m_tma;
      e_valid = req_valid;
      e_trap  = 0;
      if (req_valid) begin
        e_byp = !lvl[3];
        cz = 0;
        k = m_find(int'(req_addr[31:12]));
        if (lvl[3]) begin
          if (k < 0 || m_flg[k][0] == 0) cz = 1;
          else if (req_kind == 2'b01) cz = m_flg[k][2] ? 0 : 3;
          else if (req_kind == 2'b10) cz = m_flg[k][1] ? 0 : 2;
          else cz = m_flg[k][3] ? 0 : 2;
        end
        e_trap = (cz != 0);
        if (!lvl[3] || e_trap) e_addr = req_addr;
        else e_addr = {m_ppn[k][19:0], req_addr[11:0]};
        if (e_trap) m_tma = {req_addr[31:2], 2'(cz)};
        else if (tma_wr) m_tma = tma_wdata;
      end else if (tma_wr) m_tma = tma_wdata;
      if (dat_wr) begin
        if (dat_wdata[5]) begin
          for (int i = 0; i < N; i++) m_flg[i] = m_flg[i] & int'(dat_wdata[4:0]);
        end else begin
          slot = m_find(int'(old_tma[31:12]));
          if (slot < 0) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % N;
          end
          m_vpn[slot] = int'(old_tma[31:12]);
          m_ppn[slot] = int'(dat_wdata[31:12]);
          m_flg[slot] = int'(dat_wdata[4:0]);
          m_used[slot] = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(rsp_valid == e_valid, "R10 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      chk(rsp_trap == e_trap, "R4 trap", 32'(rsp_trap), 32'(e_trap));
      if (e_valid) chk(rsp_addr == e_addr, e_byp ? "R2 addr" : "R3 addr", rsp_addr, e_addr);
      chk(tma == m_tma, "R5 tma", tma, m_tma);
      chk(dat == m_dat(), "R6 dat", dat, m_dat());
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    req_valid = 0; req_addr = 0; req_kind = 0; tma_wr = 0; tma_wdata = 0;
    dat_wr = 0; dat_wdata = 0;
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [1:0] k,
                      input logic [3:0] l, input logic tw, input logic [31:0] twd,
                      input logic dw, input logic [31:0] dwd);
    req_valid = v; req_addr = a; req_kind = k; lvl = l;
    tma_wr = tw; tma_wdata = twd; dat_wr = dw; dat_wdata = dwd;
    @(negedge clk);
    idle();
  endtask

  task automatic sel(input logic [19:0] page);
    step(0, 0, 0, 4'h8, 1, {page, 12'h0}, 0, 0);
  endtask

  task automatic map(input logic [19:0] page, input logic [19:0] ppn, input logic [4:0] f);
    sel(page);
    step(0, 0, 0, 4'h8, 0, 0, 1, {ppn, 7'b0, f});
  endtask

  task automatic req(input logic [31:0] a, input logic [1:0] k, input logic [3:0] l);
    step(1, a, k, l, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(); lvl = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cmp_en = 1;
    chk(rsp_valid == 0 && tma == 0 && dat == 0, "R1 reset outputs", tma | dat, 0);
    req(32'h0001_0123, 2'b00, 4'h8);
    chk(rsp_trap == 1 && tma == 32'h0001_0121, "R1 empty table misses", tma, 32'h0001_0121);

    req(32'h1234_5678, 2'b01, 4'h7);
    chk(rsp_addr == 32'h1234_5678 && !rsp_trap, "R2 bypass", rsp_addr, 32'h1234_5678);

    map(20'h00010, 20'hABCDE, 5'h0F);
    chk(dat == 32'hABCD_E00F, "R6 readback", dat, 32'hABCD_E00F);
    req(32'h0001_0ABC, 2'b00, 4'h8);
    chk(rsp_addr == 32'hABCD_EABC && !rsp_trap, "R3 translate", rsp_addr, 32'hABCD_EABC);

    map(20'h00020, 20'h22222, 5'h09);
    req(32'h0002_0004, 2'b01, 4'h9);
    chk(rsp_trap && tma == 32'h0002_0007, "R4 R5 write violation", tma, 32'h0002_0007);
    chk(rsp_addr == 32'h0002_0004, "R4 trap keeps vaddr", rsp_addr, 32'h0002_0004);
    req(32'h0002_0008, 2'b10, 4'hF);
    chk(rsp_trap && tma == 32'h0002_000A, "R4 execute violation", tma, 32'h0002_000A);
    req(32'h0002_0010, 2'b11, 4'h8);
    chk(!rsp_trap && rsp_addr == 32'h2222_2010, "R4 kind 11 as read", rsp_addr, 32'h2222_2010);
    req(32'h0009_9010, 2'b00, 4'h8);
    chk(tma == 32'h0009_9011 && dat == 0, "R6 miss shows empty", dat, 0);

    map(20'h00020, 20'h33333, 5'h0F);
    map(20'h00030, 20'h44444, 5'h0F);
    map(20'h00040, 20'h55555, 5'h0F);
    map(20'h00050, 20'h66666, 5'h0F);
    sel(20'h00010);
    chk(dat == 0, "R7 round robin evicts entry 0", dat, 0);
    sel(20'h00020);
    chk(dat == 32'h3333_300F, "R7 in-place overwrite", dat, 32'h3333_300F);

    step(0, 0, 0, 4'h8, 0, 0, 1, 32'h0000_003B);
    chk(dat == 32'h3333_300B, "R8 global AND clears W", dat, 32'h3333_300B);

    sel(20'h00050);
    step(1, 32'h0005_0000, 2'b01, 4'h8, 0, 0, 1, {20'h77777, 7'b0, 5'h0F});
    chk(rsp_trap && tma == 32'h0005_0003, "R9 request sees old rights", tma, 32'h0005_0003);
    req(32'h0005_0020, 2'b01, 4'h8);
    chk(!rsp_trap && rsp_addr == 32'h7777_7020, "R9 new rights next cycle", rsp_addr, 32'h7777_7020);

    step(1, 32'h0007_7008, 2'b00, 4'h8, 1, 32'h1234_5000, 0, 0);
    chk(tma == 32'h0007_7009, "R5 trap beats tma write", tma, 32'h0007_7009);

    step(0, 0, 0, 4'h8, 0, 0, 1, 32'h0000_0020);
    req(32'h0005_0040, 2'b00, 4'h8);
    chk(rsp_trap && tma == 32'h0005_0041 && dat == 32'h7777_7000, "R8 global invalidate", dat, 32'h7777_7000);
    @(negedge clk);
    chk(!rsp_valid, "R10 idle response", 32'(rsp_valid), 0);

    for (int n = 0; n < 3000; n++) begin
      logic [19:0] pg;
      int r;
      pg = 20'h00100 + 20'($urandom_range(0, 6));
      r = $urandom_range(0, 99);
      req_valid = (r < 70);
      req_addr  = {pg, 12'($urandom)};
      req_kind  = 2'($urandom);
      lvl       = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 7)) : 4'h8 | 4'($urandom);
      tma_wr    = ($urandom_range(0, 4) == 0);
      tma_wdata = {20'h00100 + 20'($urandom_range(0, 6)), 12'h0};
      dat_wr    = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 19) == 0) dat_wdata = {27'h0, 1'b1, 4'hF, 1'($urandom)};
      else dat_wdata = {20'($urandom), 7'b0, 5'($urandom) | 5'h01};
      @(negedge clk);
    end
    idle();
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule